// File: doc/BRIEF.md
# Three-Wire Divider Word Loader

This block takes divider settings for a frequency synthesiser from a three-wire serial port. The lines are a serial clock, a data line and a latch strobe. Each frame is seventeen bits long and is sent most significant bit first. The last bit of a frame chooses the destination. The other sixteen bits carry the payload. When the strobe rises, the payload goes to one of two holding registers:

- the 16-bit feedback divider word, or
- the 13-bit reference divider word.

The two words feed the divider counters directly.

The serial lines have no fixed timing relation to the system clock. The block therefore passes all three lines through a synchroniser of selectable depth, then detects the edges of the serial clock and the strobe in the system clock domain. Serial clock edges that arrive while the strobe is high are not shifted in. Each rising edge of the strobe causes exactly one transfer, however long the strobe stays high.

Top module: `serial_divider_loader`

## Requirements
- R1: A synchronous reset sets the feedback word to N_RESET (default 992) and the reference word to R_RESET (default 5).
- R2: Each rising edge of `ser_clk` seen while `ser_latch` is low shifts `ser_data` into a 17-bit register, most significant bit first. The bit sent first ends up as payload bit 15, and the bit sent seventeenth is the select bit.
- R3: A transfer with select bit 0 copies all sixteen payload bits to `n_word` and leaves `r_word` unchanged.
- R4: A transfer with select bit 1 copies payload bits 15..3 (the first thirteen bits sent) to `r_word`. The three lowest payload bits are discarded and `n_word` is left unchanged.
- R5: A transfer happens only on a rising edge of `ser_latch`. Holding the strobe high causes no further load, at most one output word changes per transfer, and both words otherwise hold their values.
- R6: Rising edges of `ser_clk` that occur while `ser_latch` is high leave the shift register unchanged.
- R7: When the strobe rise and a serial clock rise reach the system clock domain in the same cycle, the transfer uses the register contents from before that cycle, and the clock edge is discarded.
- R8: A new word appears on its output no later than SYNC_STAGES+2 system clock cycles after `ser_latch` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data, sampled on the rising edge of `ser_clk` |
| ser_latch | input | 1 | Strobe; its rising edge transfers the frame, and it stays low while bits are shifted |
| n_word | output | 16 | Held feedback divider word |
| r_word | output | 13 | Held reference divider word |

## Verification
Shifting and transferring can both fall in one system clock cycle. This happens when a serial clock rise and a strobe rise cross the synchroniser together. The bench provokes it by driving `ser_clk` and `ser_latch` high in the same cycle, with a data bit chosen so that a wrongly accepted shift would flip the select bit. The strobe is then pulsed again with no clock edges in between. The bench judges the case by comparing both words against a model in which the shift register did not move.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    localparam int N_W     = 16;
    localparam int R_W     = 13;
    localparam int FRAME_W = N_W + 1;

    typedef enum logic {
        DEST_FEEDBACK  = 1'b0,
        DEST_REFERENCE = 1'b1
    } dest_e;

    // Payload occupies the upper bits; the last bit shifted in is the selector.
    typedef struct packed {
        logic [N_W-1:0] payload;
        dest_e          dest;
    } frame_t;

    function automatic frame_t shift_in(frame_t cur, logic bit_in);
        logic [FRAME_W-1:0] raw;
        raw = {cur[FRAME_W-2:0], bit_in};
        return frame_t'(raw);
    endfunction

    function automatic logic [R_W-1:0] ref_field(logic [N_W-1:0] payload);
        return payload[N_W-1 -: R_W];
    endfunction

endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], async_in[i]};
        end
        assign sync_out[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter
    import sdl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_lvl,
    input  logic   data_lvl,
    input  logic   latch_lvl,
    output frame_t frame,
    output logic   xfer
);

    logic sclk_q;
    logic latch_q;
    logic shift_en;

    assign shift_en = sclk_lvl && !sclk_q && !latch_lvl;
    assign xfer     = latch_lvl && !latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            latch_q <= 1'b0;
            frame   <= '0;
        end else begin
            sclk_q  <= sclk_lvl;
            latch_q <= latch_lvl;
            if (shift_en) frame <= shift_in(frame, data_lvl);
        end
    end

endmodule

// File: rtl/sdl_latch_bank.sv
module sdl_latch_bank
    import sdl_pkg::*;
#(
    parameter logic [N_W-1:0] N_RESET = 16'd992,
    parameter logic [R_W-1:0] R_RESET = 13'd5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           xfer,
    input  frame_t         frame,
    output logic [N_W-1:0] n_word,
    output logic [R_W-1:0] r_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            n_word <= N_RESET;
            r_word <= R_RESET;
        end else if (xfer) begin
            unique case (frame.dest)
                DEST_FEEDBACK:  n_word <= frame.payload;
                DEST_REFERENCE: r_word <= ref_field(frame.payload);
            endcase
        end
    end

endmodule

// File: rtl/serial_divider_loader.sv
module serial_divider_loader
    import sdl_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [N_W-1:0]  N_RESET     = 16'd992,
    parameter logic [R_W-1:0]  R_RESET     = 13'd5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_latch,
    output logic [N_W-1:0] n_word,
    output logic [R_W-1:0] r_word
);

    localparam int LINES = 3;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] lvl_lines;
    logic             sclk_lvl;
    logic             data_lvl;
    logic             latch_lvl;
    logic             xfer;
    frame_t           frame;

    assign raw_lines = {ser_latch, ser_data, ser_clk};
    assign sclk_lvl  = lvl_lines[0];
    assign data_lvl  = lvl_lines[1];
    assign latch_lvl = lvl_lines[2];

    sdl_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_lines),
        .sync_out (lvl_lines)
    );

    sdl_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk_lvl  (sclk_lvl),
        .data_lvl  (data_lvl),
        .latch_lvl (latch_lvl),
        .frame     (frame),
        .xfer      (xfer)
    );

    sdl_latch_bank #(
        .N_RESET (N_RESET),
        .R_RESET (R_RESET)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .xfer   (xfer),
        .frame  (frame),
        .n_word (n_word),
        .r_word (r_word)
    );

endmodule

// File: rtl/sdl_checker.sv
module sdl_checker
    import sdl_pkg::*;
#(
    parameter logic [N_W-1:0] N_RESET = 16'd992,
    parameter logic [R_W-1:0] R_RESET = 13'd5
) (
    input logic           clk,
    input logic           rst,
    input logic [N_W-1:0] n_word,
    input logic [R_W-1:0] r_word,
    input logic           xfer,
    input logic           latch_lvl,
    input frame_t         frame
);

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (n_word == N_RESET && r_word == R_RESET));

    // R3
    feedback_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && frame.dest == DEST_FEEDBACK) |=> (n_word == $past(frame.payload) && $stable(r_word)));

    // R4
    reference_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && frame.dest == DEST_REFERENCE) |=> (r_word == ref_field($past(frame.payload)) && $stable(n_word)));

    // R5
    load_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(n_word) || !$stable(r_word)) |-> $past(xfer));

    // R5
    single_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> !xfer);

    // R6
    frozen_shift_chk: assert property (@(posedge clk) disable iff (rst)
        latch_lvl |=> $stable(frame));

endmodule

bind serial_divider_loader sdl_checker #(
    .N_RESET (N_RESET),
    .R_RESET (R_RESET)
) u_sdl_chk (
    .clk       (clk),
    .rst       (rst),
    .n_word    (n_word),
    .r_word    (r_word),
    .xfer      (xfer),
    .latch_lvl (latch_lvl),
    .frame     (frame)
);

// File: tb/test_serial_divider_loader.sv
module test_serial_divider_loader;

    localparam int SYNC = 2;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_latch = 1'b0;
    logic [15:0] n_word;
    logic [12:0] r_word;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;

    logic [16:0] m_sr  = '0;
    logic [15:0] exp_n = 16'd992;
    logic [12:0] exp_r = 13'd5;

    always #5 clk = ~clk;

    serial_divider_loader #(.SYNC_STAGES(SYNC)) i_serial_divider_loader (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .n_word    (n_word),
        .r_word    (r_word)
    );

    function automatic logic [12:0] ref_of(logic [16:0] f);
        return f[16:4];
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_both(string req);
        chk(req, n_word, exp_n);
        chk(req, {3'b0, r_word}, {3'b0, exp_r});
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b0;
        wait_n(HALF);
        ser_clk = 1'b1;
        if (!ser_latch) m_sr = {m_sr[15:0], b};
        wait_n(HALF);
        ser_clk = 1'b0;
    endtask

    task automatic send_frame(logic [16:0] f);
        for (int i = 16; i >= 0; i--) send_bit(f[i]);
        wait_n(HALF);
    endtask

    task automatic model_xfer();
        if (m_sr[0] == 1'b0) exp_n = m_sr[16:1];
        else                 exp_r = ref_of(m_sr);
    endtask

    task automatic latch_pulse();
        @(negedge clk);
        ser_latch = 1'b1;
        model_xfer();
        wait_n(2 * HALF);
        ser_latch = 1'b0;
        wait_n(2 * HALF);
    endtask

    initial begin
        int unsigned seed_init;
        logic [16:0] f;
        logic [15:0] saved_n;
        seed_init = $urandom(32'h5EED);
        wait_n(4);
        rst = 1'b0;
        wait_n(2);

        // R1: reset values
        chk("R1", n_word, 16'd992);
        chk("R1", {3'b0, r_word}, 16'd5);

        // R2 R3: feedback word load, MSB first
        send_frame({16'hA5C3, 1'b0});
        latch_pulse();
        chk_both("R3");
        chk("R2", n_word, 16'hA5C3);

        // R4: reference load keeps top 13 bits only
        send_frame({16'hFFFF, 1'b1});
        latch_pulse();
        chk_both("R4");
        chk("R4", {3'b0, r_word}, 16'h1FFF);
        send_frame({16'h000F, 1'b1});
        latch_pulse();
        chk("R4", {3'b0, r_word}, 16'h0001);
        chk("R4", n_word, 16'hA5C3);

        // R8: latency from strobe rise
        send_frame({16'h1234, 1'b0});
        @(negedge clk);
        ser_latch = 1'b1;
        model_xfer();
        wait_n(SYNC + 2);
        chk("R8", n_word, 16'h1234);
        wait_n(2 * HALF);

        // R6 R5: clocks ignored while strobe held high, no repeat loads
        saved_n = n_word;
        send_frame({16'h0F0F, 1'b0});
        chk("R5", n_word, saved_n);
        ser_latch = 1'b0;
        wait_n(2 * HALF);
        latch_pulse();
        chk("R6", n_word, 16'h1234);
        chk_both("R6");

        // R7: strobe rise and clock rise in the same cycle
        send_frame({16'h8421, 1'b0});
        @(negedge clk);
        ser_data  = 1'b1;
        ser_clk   = 1'b1;
        ser_latch = 1'b1;
        model_xfer();
        wait_n(2 * HALF);
        ser_clk = 1'b0;
        wait_n(HALF);
        ser_latch = 1'b0;
        wait_n(2 * HALF);
        chk("R7", n_word, 16'h8421);
        latch_pulse();
        chk("R7", n_word, 16'h8421);
        chk_both("R7");

        // R2 R3 R4 R5: random frames
        for (int k = 0; k < 24; k++) begin
            f = 17'($urandom());
            send_frame(f);
            latch_pulse();
            chk_both(f[0] ? "R4" : "R3");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule